// File: doc/BRIEF.md
# Sliding-Window Jet Cluster Finder

This block searches one module's patch of calorimeter jet elements for energy clusters. Every clock it accepts a complete frame of 11 (eta) by 7 (phi) element energies. It forms 2x2, 3x3 and 4x4 window sums and picks out the 2x2 sums that are local maxima among their neighbours. It then compares the sum of one selected window size against a programmable threshold. The result is a hit map with one bit per 2x2 position, together with the number of hits in that map.

The larger windows are not built with adder trees of their own. A 3x3 sum is a 2x2 sum plus one element pair and one column of three elements. A 4x4 sum adds four 2x2 sums that already exist. Each comparison between two neighbouring 2x2 sums is made once, and both positions use its result. The window size and the threshold travel down the pipeline with the frame, so consecutive frames may use different settings. The result appears a fixed four clock edges after the frame is captured.

Top module: `jet_window_finder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `hitMap` and `hitCount` are all zero.
- R2: With `sizeSelIn` = 0, a position's cluster sum is its 2x2 sum. Position (e,p), with e in 0..9 and p in 0..5, covers the elements e..e+1 by p..p+1. Its hit bit is `hitMap[p*10+e]`.
- R3: With `sizeSelIn` = 1, a position's cluster sum covers the elements e..e+2 by p..p+2. Only positions with e<=8 and p<=4 can hit.
- R4: With `sizeSelIn` = 2 or 3, a position's cluster sum covers the elements e-1..e+2 by p-1..p+2. Only positions with 1<=e<=8 and 1<=p<=4 can hit.
- R5: A position can hit only if its 2x2 sum is a local maximum. Each of the up to eight neighbours is either earlier in raster order (lower p, or the same p and lower e) or later. The sum must be >= every earlier neighbour and > every later one. A flat plateau therefore yields exactly one maximum, at its raster-last position.
- R6: A local maximum hits only when its selected cluster sum is strictly greater than `thrIn`. A sum equal to the threshold does not hit.
- R7: A frame and its settings are captured together on a rising edge. Its result is on the outputs after the fourth rising edge, counting the capturing one, and not earlier. Frames may follow one another on every cycle, each with its own settings.
- R8: `hitCount` equals the number of set bits in `hitMap` in the same cycle.
- R9: Window sums are exact up to 16 full-scale elements (16*1023). The threshold is 14 bits wide.
- R10: Element (e,p), with e in 0..10 and p in 0..6, is the 10-bit unsigned field `frameIn[(p*11+e)*10 +: 10]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameIn | input | 770 | One frame of 77 jet-element energies |
| thrIn | input | 14 | Cluster threshold, captured with the frame |
| sizeSelIn | input | 2 | Window size select: 0 = 2x2, 1 = 3x3, 2 or 3 = 4x4 |
| hitMap | output | 60 | One hit bit per 2x2 position |
| hitCount | output | 6 | Number of set bits in hitMap |

## Verification
The hardest cases to reach from the ports are the tie-breaking cases: several neighbouring 2x2 sums that are exactly equal, where a rule applied in the wrong direction would keep two maxima or none. The stimulus builds these on purpose. An isolated spike makes four equal 2x2 sums. A uniform frame makes one plateau over the whole grid. A block of full-scale elements with a ring of slightly smaller ones around it gives 3x3 and 4x4 sums that are known exactly, so the threshold can be set one below and exactly at the sum. Back-to-back frames with different window sizes and thresholds show that the settings stay with their own frame through the pipeline.

// File: rtl/jwf_pkg.sv
package jwf_pkg;

  // Window-size strobes handed from control to datapath; exactly one is set.
  typedef struct packed {
    logic sel2;
    logic sel3;
    logic sel4;
  } winSel_t;

  function automatic winSel_t decodeSize(input logic [1:0] code);
    winSel_t s;
    s = '0;
    case (code)
      2'd0:    s.sel2 = 1'b1;
      2'd1:    s.sel3 = 1'b1;
      default: s.sel4 = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/jwf_ctrl.sv
module jwf_ctrl
  import jwf_pkg::*;
#(
  parameter int THR_W = 14,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sizeSelIn,
  input  logic [THR_W-1:0] thrIn,
  output winSel_t          selOut,
  output logic [THR_W-1:0] thrOut
);

  winSel_t          selPipe [DEPTH];
  logic [THR_W-1:0] thrPipe [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selPipe[0] <= decodeSize(2'd0);
      thrPipe[0] <= '0;
    end else begin
      selPipe[0] <= decodeSize(sizeSelIn);
      thrPipe[0] <= thrIn;
    end
  end

  // Settings follow the frame stage by stage so they meet it at the compare.
  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        selPipe[k] <= decodeSize(2'd0);
        thrPipe[k] <= '0;
      end else begin
        selPipe[k] <= selPipe[k-1];
        thrPipe[k] <= thrPipe[k-1];
      end
    end
  end

  assign selOut = selPipe[DEPTH-1];
  assign thrOut = thrPipe[DEPTH-1];

  // R2: exactly one window size is active at the compare stage.
  p_one_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(selOut));

  // R4: the spare code 3 selects the 4x4 window.
  p_code3_as_4x4_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sizeSelIn == 2'd3) |=> selPipe[0].sel4);

endmodule

// File: rtl/jwf_sums.sv
module jwf_sums #(
  parameter int NETA = 11,
  parameter int NPHI = 7,
  parameter int EW   = 10,
  parameter int SW   = EW + 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NETA*NPHI*EW-1:0]               frameIn,
  output logic [(NETA-1)*(NPHI-1)*SW-1:0]       s2Now,
  output logic [(NETA-1)*(NPHI-1)*SW-1:0]       s2Out,
  output logic [(NETA-1)*(NPHI-1)*SW-1:0]       s3Out,
  output logic [(NETA-1)*(NPHI-1)*SW-1:0]       s4Out
);

  localparam int NPE = NETA - 1;
  localparam int NPP = NPHI - 1;

  // Stage 1: captured elements, zero-extended to sum width.
  logic [SW-1:0] elR1   [NPHI][NETA];
  // Stage 2: horizontal pairs, 2x2 sums, and the elements the 3x3 still needs.
  logic [SW-1:0] pairC  [NPHI][NETA-1];
  logic [SW-1:0] pairR2 [NPHI-2][NETA-2];   // row r holds pair row r+2
  logic [SW-1:0] elR2   [NPHI][NETA-2];     // column c holds element column c+2
  logic [SW-1:0] s2C    [NPP][NPE];
  logic [SW-1:0] s2R2   [NPP][NPE];
  // Stage 3: all three window sizes.
  logic [SW-1:0] s2R3   [NPP][NPE];
  logic [SW-1:0] s3R3   [NPP][NPE];
  logic [SW-1:0] s4R3   [NPP][NPE];

  for (genvar p = 0; p < NPHI; p++) begin : g_elRow
    for (genvar e = 0; e < NETA; e++) begin : g_elCol
      always_ff @(posedge clk) begin
        if (!rst_n) elR1[p][e] <= '0;
        else        elR1[p][e] <= {{(SW-EW){1'b0}}, frameIn[(p*NETA+e)*EW +: EW]};
      end
      if (e >= 2) begin : g_keep
        always_ff @(posedge clk) begin
          if (!rst_n) elR2[p][e-2] <= '0;
          else        elR2[p][e-2] <= elR1[p][e];
        end
      end
    end
  end

  for (genvar p = 0; p < NPHI; p++) begin : g_pairRow
    for (genvar e = 0; e < NETA - 1; e++) begin : g_pairCol
      assign pairC[p][e] = elR1[p][e] + elR1[p][e+1];
      if (p >= 2 && e < NETA - 2) begin : g_keep
        always_ff @(posedge clk) begin
          if (!rst_n) pairR2[p-2][e] <= '0;
          else        pairR2[p-2][e] <= pairC[p][e];
        end
      end
    end
  end

  for (genvar p = 0; p < NPP; p++) begin : g_winRow
    for (genvar e = 0; e < NPE; e++) begin : g_winCol
      localparam int IDX = p * NPE + e;
      localparam bit FIT3 = (e < NPE - 1) && (p < NPP - 1);
      localparam bit FIT4 = (e >= 1) && (e <= NPE - 2) && (p >= 1) && (p <= NPP - 2);

      assign s2C[p][e] = pairC[p][e] + pairC[p+1][e];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s2R2[p][e] <= '0;
          s2R3[p][e] <= '0;
        end else begin
          s2R2[p][e] <= s2C[p][e];
          s2R3[p][e] <= s2R2[p][e];
        end
      end

      if (FIT3) begin : g_w3
        // 2x2 core + the pair above it + the column of three to its right.
        always_ff @(posedge clk) begin
          if (!rst_n) s3R3[p][e] <= '0;
          else        s3R3[p][e] <= s2R2[p][e] + pairR2[p][e]
                                    + elR2[p][e] + elR2[p+1][e] + elR2[p+2][e];
        end
        // R3: the 3x3 window contains its 2x2 core.
        p_win3_covers_core_r3: assert property (@(posedge clk) disable iff (!rst_n)
          s3R3[p][e] >= s2R3[p][e]);
      end else begin : g_n3
        always_ff @(posedge clk) s3R3[p][e] <= '0;
      end

      if (FIT4) begin : g_w4
        // Four disjoint 2x2 sums around the position tile the 4x4 window.
        always_ff @(posedge clk) begin
          if (!rst_n) s4R3[p][e] <= '0;
          else        s4R3[p][e] <= s2R2[p-1][e-1] + s2R2[p-1][e+1]
                                    + s2R2[p+1][e-1] + s2R2[p+1][e+1];
        end
        // R4: the 4x4 window contains the 2x2 core at its centre.
        p_win4_covers_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
          s4R3[p][e] >= s2R3[p][e]);
      end else begin : g_n4
        always_ff @(posedge clk) s4R3[p][e] <= '0;
      end

      assign s2Now[IDX*SW +: SW] = s2R2[p][e];
      assign s2Out[IDX*SW +: SW] = s2R3[p][e];
      assign s3Out[IDX*SW +: SW] = s3R3[p][e];
      assign s4Out[IDX*SW +: SW] = s4R3[p][e];
    end
  end

endmodule

// File: rtl/jwf_peak.sv
module jwf_peak
  import jwf_pkg::*;
#(
  parameter int NETA = 11,
  parameter int NPHI = 7,
  parameter int SW   = 14,
  parameter int CNT_W = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [(NETA-1)*(NPHI-1)*SW-1:0] s2Now,
  input  logic [(NETA-1)*(NPHI-1)*SW-1:0] s2In,
  input  logic [(NETA-1)*(NPHI-1)*SW-1:0] s3In,
  input  logic [(NETA-1)*(NPHI-1)*SW-1:0] s4In,
  input  winSel_t                         sel,
  input  logic [SW-1:0]                   thr,
  output logic [(NETA-1)*(NPHI-1)-1:0]    hitMap,
  output logic [CNT_W-1:0]                hitCount
);

  localparam int NPE  = NETA - 1;
  localparam int NPP  = NPHI - 1;
  localparam int NPOS = NPE * NPP;

  // cmpR[i][d]: the raster-later neighbour of i in direction d has a sum >= i's.
  // Directions: 0 = (+1,0), 1 = (-1,+1), 2 = (0,+1), 3 = (+1,+1).
  logic [3:0]      cmpR [NPOS];
  logic [NPOS-1:0] hitC;

  for (genvar p = 0; p < NPP; p++) begin : g_row
    for (genvar e = 0; e < NPE; e++) begin : g_col
      localparam int IDX = p * NPE + e;
      localparam bit FIT3 = (e < NPE - 1) && (p < NPP - 1);
      localparam bit FIT4 = (e >= 1) && (e <= NPE - 2) && (p >= 1) && (p <= NPP - 2);

      logic [3:0]    cmpC;
      logic [3:0]    winEarly;
      logic          isMax;
      logic [SW-1:0] selSum;
      logic          fitOk;

      for (genvar d = 0; d < 4; d++) begin : g_dir
        localparam int DE = (d == 0) ? 1 : (d == 1) ? -1 : (d == 2) ? 0 : 1;
        localparam int DP = (d == 0) ? 0 : 1;
        // One comparator per neighbour pair, owned by the raster-earlier side.
        if ((e + DE >= 0) && (e + DE < NPE) && (p + DP < NPP)) begin : g_cmp
          assign cmpC[d] = s2Now[((p+DP)*NPE + e + DE)*SW +: SW] >= s2Now[IDX*SW +: SW];
        end else begin : g_nocmp
          assign cmpC[d] = 1'b0;
        end
        // The earlier neighbour's comparator, read as-is, says this side wins on >=.
        if ((e - DE >= 0) && (e - DE < NPE) && (p - DP >= 0)) begin : g_early
          assign winEarly[d] = cmpR[(p-DP)*NPE + e - DE][d];
        end else begin : g_noearly
          assign winEarly[d] = 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) cmpR[IDX] <= '0;
        else        cmpR[IDX] <= cmpC;
      end

      assign isMax = ~|cmpR[IDX] & (&winEarly);

      always_comb begin
        if (sel.sel2)      selSum = s2In[IDX*SW +: SW];
        else if (sel.sel3) selSum = s3In[IDX*SW +: SW];
        else               selSum = s4In[IDX*SW +: SW];
        fitOk = sel.sel2 | (sel.sel3 & FIT3) | (sel.sel4 & FIT4);
      end

      assign hitC[IDX] = isMax & fitOk & (selSum > thr);

      if (e < NPE - 1) begin : g_chkE
        // R5: two eta neighbours can never both be maxima.
        p_no_adjacent_eta_r5: assert property (@(posedge clk) disable iff (!rst_n)
          !(hitMap[IDX] && hitMap[IDX+1]));
      end
      if (p < NPP - 1) begin : g_chkP
        // R5: two phi neighbours can never both be maxima.
        p_no_adjacent_phi_r5: assert property (@(posedge clk) disable iff (!rst_n)
          !(hitMap[IDX] && hitMap[IDX+NPE]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitMap   <= '0;
      hitCount <= '0;
    end else begin
      hitMap   <= hitC;
      hitCount <= CNT_W'($countones(hitC));
    end
  end

  // R8: the count always agrees with the map it accompanies.
  p_count_matches_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hitCount == CNT_W'($countones(hitMap)));

endmodule

// File: rtl/jet_window_finder.sv
module jet_window_finder
  import jwf_pkg::*;
#(
  parameter int NETA = 11,
  parameter int NPHI = 7,
  parameter int EW   = 10
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NETA*NPHI*EW-1:0]                   frameIn,
  input  logic [EW+3:0]                             thrIn,
  input  logic [1:0]                                sizeSelIn,
  output logic [(NETA-1)*(NPHI-1)-1:0]              hitMap,
  output logic [$clog2((NETA-1)*(NPHI-1)+1)-1:0]    hitCount
);

  localparam int SW    = EW + 4;                 // holds 16 full-scale elements
  localparam int NPOS  = (NETA - 1) * (NPHI - 1);
  localparam int CNT_W = $clog2(NPOS + 1);

  winSel_t          selStage;
  logic [SW-1:0]    thrStage;
  logic [NPOS*SW-1:0] s2Now, s2Out, s3Out, s4Out;

  jwf_ctrl #(.THR_W(SW), .DEPTH(3)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sizeSelIn (sizeSelIn),
    .thrIn     (thrIn),
    .selOut    (selStage),
    .thrOut    (thrStage)
  );

  jwf_sums #(.NETA(NETA), .NPHI(NPHI), .EW(EW), .SW(SW)) u_sums (
    .clk     (clk),
    .rst_n   (rst_n),
    .frameIn (frameIn),
    .s2Now   (s2Now),
    .s2Out   (s2Out),
    .s3Out   (s3Out),
    .s4Out   (s4Out)
  );

  jwf_peak #(.NETA(NETA), .NPHI(NPHI), .SW(SW), .CNT_W(CNT_W)) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .s2Now    (s2Now),
    .s2In     (s2Out),
    .s3In     (s3Out),
    .s4In     (s4Out),
    .sel      (selStage),
    .thr      (thrStage),
    .hitMap   (hitMap),
    .hitCount (hitCount)
  );

endmodule

// File: tb/tb_jet_window_finder.sv
module tb_jet_window_finder;

  localparam int NETA = 11;
  localparam int NPHI = 7;
  localparam int EW   = 10;
  localparam int NPE  = NETA - 1;
  localparam int NPP  = NPHI - 1;
  localparam int NPOS = NPE * NPP;
  localparam int FW   = NETA * NPHI * EW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [FW-1:0]   frameIn = '0;
  logic [EW+3:0]   thrIn = '0;
  logic [1:0]      sizeSelIn = '0;
  logic [NPOS-1:0] hitMap;
  logic [5:0]      hitCount;

  int nChk = 0;
  int nFail = 0;
  logic [FW-1:0] fr;

  jet_window_finder dut (
    .clk (clk), .rst_n (rst_n), .frameIn (frameIn), .thrIn (thrIn),
    .sizeSelIn (sizeSelIn), .hitMap (hitMap), .hitCount (hitCount)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    nChk++;
    nFail++;
    $display("FAIL R7 watchdog: got no finish, expected finish within 200000 cycles");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  // ---------------- reference model built from the requirements ----------------
  function automatic int elv(input logic [FW-1:0] f, input int e, input int p);
    return int'(f[(p*NETA+e)*EW +: EW]);
  endfunction

  function automatic int s2m(input logic [FW-1:0] f, input int e, input int p);
    return elv(f, e, p) + elv(f, e+1, p) + elv(f, e, p+1) + elv(f, e+1, p+1);
  endfunction

  function automatic logic [NPOS-1:0] model(input logic [FW-1:0] f, input int thr, input int sel);
    logic [NPOS-1:0] m;
    m = '0;
    for (int p = 0; p < NPP; p++) begin
      for (int e = 0; e < NPE; e++) begin
        int s, w;
        bit lm, ok;
        s = s2m(f, e, p);
        lm = 1;
        for (int dp = -1; dp <= 1; dp++) begin
          for (int de = -1; de <= 1; de++) begin
            int en, pn;
            en = e + de;
            pn = p + dp;
            if ((de != 0 || dp != 0) && en >= 0 && en < NPE && pn >= 0 && pn < NPP) begin
              if (pn > p || (pn == p && en > e)) begin
                if (!(s > s2m(f, en, pn))) lm = 0;
              end else begin
                if (!(s >= s2m(f, en, pn))) lm = 0;
              end
            end
          end
        end
        w = 0;
        ok = 0;
        if (sel == 0) begin
          ok = 1;
          w = s;
        end else if (sel == 1) begin
          ok = (e <= NPE - 2) && (p <= NPP - 2);
          if (ok) for (int b = 0; b < 3; b++) for (int a = 0; a < 3; a++) w += elv(f, e+a, p+b);
        end else begin
          ok = (e >= 1) && (e <= NPE - 2) && (p >= 1) && (p <= NPP - 2);
          if (ok) for (int b = -1; b < 3; b++) for (int a = -1; a < 3; a++) w += elv(f, e+a, p+b);
        end
        m[p*NPE+e] = lm && ok && (w > thr);
      end
    end
    return m;
  endfunction

  // ---------------- helpers ----------------
  task automatic setEl(input int e, input int p, input int v);
    fr[(p*NETA+e)*EW +: EW] = EW'(v);
  endtask

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input int thr, input int sel);
    frameIn   = fr;
    thrIn     = (EW+4)'(thr);
    sizeSelIn = 2'(sel);
  endtask

  task automatic runFrame(input string req, input int thr, input int sel);
    logic [NPOS-1:0] exp;
    exp = model(fr, thr, sel);
    @(negedge clk);
    drive(thr, sel);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(req, "hit map", {4'b0, hitMap}, {4'b0, exp});
    check(req, "hit count", {58'b0, hitCount}, 64'($countones(exp)));
  endtask

  function automatic logic [63:0] bitAt(input int i);
    return 64'(1) << i;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1", "map in reset", {4'b0, hitMap}, 64'd0);
    check("R1", "count in reset", {58'b0, hitCount}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "map after release", {4'b0, hitMap}, 64'd0);
    check("R1", "count after release", {58'b0, hitCount}, 64'd0);
  endtask

  task automatic t_spike();
    fr = '0;
    setEl(5, 3, 500);   // four equal 2x2 sums; raster-last (5,3) -> bit 35
    runFrame("R10", 100, 0);
    check("R2", "spike explicit", {4'b0, hitMap}, bitAt(35));
  endtask

  task automatic t_threshold();
    fr = '0;
    setEl(5, 3, 500);
    runFrame("R6", 500, 0);
    check("R6", "equal threshold", {4'b0, hitMap}, 64'd0);
    runFrame("R6", 499, 0);
    check("R6", "one below", {4'b0, hitMap}, bitAt(35));
  endtask

  task automatic t_plateau();
    fr = '0;
    for (int p = 0; p < NPHI; p++) for (int e = 0; e < NETA; e++) setEl(e, p, 7);
    runFrame("R5", 0, 0);
    check("R5", "plateau single max", {4'b0, hitMap}, bitAt(59));
  endtask

  task automatic t_edge3();
    fr = '0;
    setEl(10, 6, 300);
    runFrame("R3", 10, 1);
    check("R3", "corner outside 3x3 range", {4'b0, hitMap}, 64'd0);
    runFrame("R2", 10, 0);
    check("R2", "corner with 2x2", {4'b0, hitMap}, bitAt(59));
    fr = '0;
    setEl(5, 3, 500);
    runFrame("R3", 100, 1);
    check("R3", "interior 3x3", {4'b0, hitMap}, bitAt(35));
  endtask

  task automatic t_wide();
    // Full-scale 2x2 core at (2,2) inside a ring of 1022 covering e,p = 1..4.
    fr = '0;
    for (int p = 1; p <= 4; p++) for (int e = 1; e <= 4; e++) setEl(e, p, 1022);
    for (int p = 2; p <= 3; p++) for (int e = 2; e <= 3; e++) setEl(e, p, 1023);
    runFrame("R4", 16355, 2);
    check("R9", "4x4 sum 16356 above 16355", {4'b0, hitMap}, bitAt(22));
    runFrame("R4", 16356, 2);
    check("R9", "4x4 sum at threshold", {4'b0, hitMap}, 64'd0);
    runFrame("R4", 16355, 3);
    check("R4", "code 3 acts as 4x4", {4'b0, hitMap}, bitAt(22));
    runFrame("R9", 9201, 1);
    check("R9", "3x3 sum 9202", {4'b0, hitMap}, bitAt(22));
  endtask

  task automatic t_count();
    fr = '0;
    setEl(1, 1, 300);
    setEl(6, 1, 400);
    setEl(2, 4, 200);
    setEl(8, 5, 600);
    runFrame("R8", 100, 0);
    check("R8", "four clusters", {58'b0, hitCount}, 64'd4);
    runFrame("R8", 250, 0);
    check("R8", "three above 250", {58'b0, hitCount}, 64'd3);
  endtask

  task automatic t_latency();
    fr = '0;
    runFrame("R7", 0, 0);
    setEl(5, 3, 500);
    @(negedge clk);
    drive(100, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", "not yet after third edge", {4'b0, hitMap}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R7", "present after fourth edge", {4'b0, hitMap}, bitAt(35));
  endtask

  task automatic t_stream();
    logic [FW-1:0]   sf  [4];
    int              sth [4];
    int              ssl [4];
    logic [NPOS-1:0] sx  [4];
    fr = '0; setEl(5, 3, 500);
    sf[0] = fr; sth[0] = 100; ssl[0] = 0;
    fr = '0;
    for (int p = 1; p <= 4; p++) for (int e = 1; e <= 4; e++) setEl(e, p, 1022);
    for (int p = 2; p <= 3; p++) for (int e = 2; e <= 3; e++) setEl(e, p, 1023);
    sf[1] = fr; sth[1] = 16355; ssl[1] = 2;
    fr = '0; setEl(1, 1, 300); setEl(6, 1, 400); setEl(2, 4, 200); setEl(8, 5, 600);
    sf[2] = fr; sth[2] = 250; ssl[2] = 0;
    fr = '0;
    for (int p = 0; p < NPHI; p++) for (int e = 0; e < NETA; e++) setEl(e, p, 7);
    sf[3] = fr; sth[3] = 0; ssl[3] = 1;
    for (int k = 0; k < 4; k++) sx[k] = model(sf[k], sth[k], ssl[k]);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        check("R7", $sformatf("stream frame %0d map", j - 4), {4'b0, hitMap}, {4'b0, sx[j-4]});
        check("R8", $sformatf("stream frame %0d count", j - 4), {58'b0, hitCount},
              64'($countones(sx[j-4])));
      end
      fr = (j < 4) ? sf[j] : '0;
      drive((j < 4) ? sth[j] : 0, (j < 4) ? ssl[j] : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_spike();
    t_threshold();
    t_plateau();
    t_edge3();
    t_wide();
    t_count();
    t_latency();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule